// File: doc/BRIEF.md
# Iterative Rotation CORDIC Sine/Cosine Unit

This block computes the cosine and sine of a signed angle using only shifts, adds and a small table of arctangent constants. A one-cycle start pulse hands it an angle in radians. The unit loads a start vector on the x axis and turns it toward the requested angle in a fixed number of micro-rotations, one per clock. Each micro-rotation turns the vector by the angle whose tangent is 2^-i. The direction of each turn is chosen by the sign of the angle still left to cover.

The start vector already carries the reciprocal of the accumulated rotation gain, so no multiply is needed at the end. After the last step the unit pulses done and presents the rounded x as the cosine and the rounded y as the sine. It always runs its full step count and never stops early, whatever the angle. The caller must keep the angle inside the convergence range of about ±99.88°.

Top module: `cordic_rot`

## Requirements
- R1: While rst_n is low and after its release, busy and done are 0 and cos_out and sin_out are 0.
- R2: A start pulse seen while busy is 0 is accepted on that clock edge: the angle is captured and busy reads 1 after that edge.
- R3: done goes high exactly ITERS clock edges after the edge that accepted start, stays high for one cycle only, and busy falls on that same edge.
- R4: start is ignored while busy is 1: it changes neither the result of the running computation nor its done timing, and it raises no later done.
- R5: angle_in is signed radians with FRAC fraction bits (default 19 bits, 16 fraction bits). cos_out and sin_out are signed with FRAC fraction bits (default 18 bits). For any angle within ±1.74 rad, each output is within 2·2^-(ITERS-1) + 4·2^-FRAC of the true cosine and sine.
- R6: An angle of exactly 0 gives cos_out within tolerance of 1.0 (65536 at the defaults) and sin_out within tolerance of 0. A residual of zero counts as non-negative and turns the vector positively.
- R7: cos_out and sin_out change only on the edge that raises done, and hold their value until the next done.
- R8: The number of cycles from start to done is the same for every angle, including those that leave a zero residual part way through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a computation |
| angle_in | input | ANG_W | Signed angle in radians, FRAC fraction bits |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| cos_out | output | OUT_W | Signed cosine, FRAC fraction bits |
| sin_out | output | OUT_W | Signed sine, FRAC fraction bits |

## Verification
The hardest thing to bring about from the ports is a second start that arrives while a rotation is in flight. If the unit did not ignore it, it would reload the vector, so the result would follow the wrong angle and done would come late or twice. The bench pulses start with a very different angle in the middle of a run. It then checks that the result matches the first angle, that done arrives on the original cycle, and that no further done follows. Angles near ±99.7° and exactly zero are swept alongside a dense grid. These push the residual to the edge of convergence and onto the sign boundary.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    // arctangent of 2^-i, by series for i >= 1
    function automatic real atan_pow2(input int i);
        real t, t2, p, acc;
        if (i == 0) return 0.78539816339744831;
        t   = 1.0 / (2.0 ** i);
        t2  = t * t;
        p   = t;
        acc = 0.0;
        for (int k = 0; k < 24; k++) begin
            if (k % 2 == 0) acc = acc + p / (2.0 * k + 1.0);
            else            acc = acc - p / (2.0 * k + 1.0);
            p = p * t2;
        end
        return acc;
    endfunction

    // reciprocal of the accumulated gain after n micro-rotations
    function automatic real inv_gain(input int n);
        real k;
        k = 1.0;
        for (int i = 0; i < n; i++)
            k = k / $sqrt(1.0 + 2.0 ** (-2.0 * i));
        return k;
    endfunction

    function automatic int to_fixed(input real v, input int frac);
        return $rtoi(v * (2.0 ** frac) + 0.5);
    endfunction

endpackage

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom #(
    parameter int ITERS = 16,
    parameter int ZW    = 22,
    parameter int ZFRAC = 19,
    localparam int IDX_W = (ITERS > 1) ? $clog2(ITERS) : 1
) (
    input  logic [IDX_W-1:0]     idx,
    output logic signed [ZW-1:0] atan_o
);
    logic signed [ZW-1:0] tbl [ITERS];

    for (genvar g = 0; g < ITERS; g++) begin : g_ent
        localparam int VAL = cordic_pkg::to_fixed(cordic_pkg::atan_pow2(g), ZFRAC);
        assign tbl[g] = ZW'(VAL);
    end

    assign atan_o = tbl[idx];
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
    parameter int XW    = 21,
    parameter int ZW    = 22,
    parameter int IDX_W = 4
) (
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] y_i,
    input  logic signed [ZW-1:0] z_i,
    input  logic signed [ZW-1:0] atan_i,
    input  logic [IDX_W-1:0]     sh_i,
    output logic signed [XW-1:0] x_o,
    output logic signed [XW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);
    logic                 pos;
    logic signed [XW-1:0] xs, ys;

    always_comb begin
        pos = ~z_i[ZW-1];          // zero residual turns positively
        xs  = x_i >>> sh_i;
        ys  = y_i >>> sh_i;
        if (pos) begin
            x_o = x_i - ys;
            y_o = y_i + xs;
            z_o = z_i - atan_i;
        end else begin
            x_o = x_i + ys;
            y_o = y_i - xs;
            z_o = z_i + atan_i;
        end
    end
endmodule

// File: rtl/cordic_rot.sv
module cordic_rot #(
    parameter int ITERS = 16,
    parameter int FRAC  = 16,
    parameter int ANG_W = 19,
    parameter int OUT_W = 18,
    parameter int GUARD = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [ANG_W-1:0] angle_in,
    output logic                    busy,
    output logic                    done,
    output logic signed [OUT_W-1:0] cos_out,
    output logic signed [OUT_W-1:0] sin_out
);
    localparam int XW    = OUT_W + GUARD;
    localparam int ZW    = ANG_W + GUARD;
    localparam int XFRAC = FRAC + GUARD;
    localparam int IDX_W = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam int K_INT = cordic_pkg::to_fixed(cordic_pkg::inv_gain(ITERS), XFRAC);
    localparam logic signed [XW-1:0] K_FIX = XW'(K_INT);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ITERS - 1);

    typedef struct packed {
        logic                    busy;
        logic                    done;
        logic [IDX_W-1:0]        idx;
        logic signed [XW-1:0]    x;
        logic signed [XW-1:0]    y;
        logic signed [ZW-1:0]    z;
        logic signed [OUT_W-1:0] c;
        logic signed [OUT_W-1:0] s;
    } state_t;

    state_t st_d, st_q;

    logic signed [ZW-1:0] atan_w;
    logic signed [XW-1:0] xn_w, yn_w;
    logic signed [ZW-1:0] zn_w;

    cordic_atan_rom #(.ITERS(ITERS), .ZW(ZW), .ZFRAC(XFRAC)) u_rom (
        .idx    (st_q.idx),
        .atan_o (atan_w)
    );

    cordic_stage #(.XW(XW), .ZW(ZW), .IDX_W(IDX_W)) u_stage (
        .x_i    (st_q.x),
        .y_i    (st_q.y),
        .z_i    (st_q.z),
        .atan_i (atan_w),
        .sh_i   (st_q.idx),
        .x_o    (xn_w),
        .y_o    (yn_w),
        .z_o    (zn_w)
    );

    function automatic logic signed [OUT_W-1:0] round_out(input logic signed [XW-1:0] v);
        logic signed [XW:0] t;
        t = {v[XW-1], v} + ((XW+1)'(1) << (GUARD - 1));
        return t[OUT_W+GUARD-1:GUARD];
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.x = xn_w;
            st_d.y = yn_w;
            st_d.z = zn_w;
            if (st_q.idx == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.c    = round_out(xn_w);
                st_d.s    = round_out(yn_w);
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.x    = K_FIX;
            st_d.y    = '0;
            st_d.z    = {angle_in, {GUARD{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign cos_out = st_q.c;
    assign sin_out = st_q.s;
endmodule

// File: rtl/cordic_rot_chk.sv
module cordic_rot_chk #(
    parameter int ITERS = 16,
    parameter int OUT_W = 18
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic signed [OUT_W-1:0] cos_out,
    input logic signed [OUT_W-1:0] sin_out
);
    localparam int CW = $clog2(ITERS + 2) + 1;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)              run_cnt <= '0;
        else if (start && !busy) run_cnt <= '0;
        else if (busy)           run_cnt <= run_cnt + 1'b1;
    end

    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: fixed step count regardless of angle
    a_r8_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == CW'(ITERS)));

    a_r7_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(cos_out) && $stable(sin_out)));
endmodule

bind cordic_rot cordic_rot_chk #(.ITERS(ITERS), .OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .cos_out (cos_out),
    .sin_out (sin_out)
);

// File: tb/cordic_rot_tb.sv
`timescale 1ns/1ps
module cordic_rot_tb;
    localparam int ITERS = 16;
    localparam int FRAC  = 16;
    localparam int ANG_W = 19;
    localparam int OUT_W = 18;
    localparam real SCALE = 65536.0;
    localparam real TOL = 2.0 * (2.0 ** (-(ITERS - 1))) + 4.0 / SCALE;

    logic clk = 0, rst_n = 0, start = 0;
    logic signed [ANG_W-1:0] angle_in = '0;
    logic busy, done;
    logic signed [OUT_W-1:0] cos_out, sin_out;

    int n_chk = 0, n_err = 0;

    cordic_rot #(.ITERS(ITERS), .FRAC(FRAC), .ANG_W(ANG_W), .OUT_W(OUT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .angle_in(angle_in),
        .busy(busy), .done(done), .cos_out(cos_out), .sin_out(sin_out)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%f expected=%f", req, what, act, exp);
        end
    endtask

    function automatic real absr(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    // start at a negedge, return cycles until done seen at a negedge
    task automatic launch(input int ang_fix, output int lat);
        angle_in = ANG_W'(ang_fix);
        start = 1;
        @(negedge clk);
        start = 0;
        check(busy == 1'b1, "R2", "busy after start", real'(busy), 1.0);
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (done || lat > 60) break;
        end
    endtask

    task automatic run_angle(input real a, input string req);
        int   af, lat;
        real  ar, ec, es, c, s;
        af = $rtoi(a * SCALE);
        ar = $itor(af) / SCALE;
        launch(af, lat);
        check(lat == ITERS, "R8", "latency", real'(lat), real'(ITERS));
        ec = $cos(ar);
        es = $sin(ar);
        c  = $itor(cos_out) / SCALE;
        s  = $itor(sin_out) / SCALE;
        check(absr(c - ec) <= TOL, req, "cos", c, ec);
        check(absr(s - es) <= TOL, req, "sin", s, es);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R3", "done single cycle", real'(done), 0.0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int lat, cnt_done;
        logic signed [OUT_W-1:0] hc, hs;
        real c, s;

        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && cos_out == 0 && sin_out == 0,
              "R1", "reset state", real'(cos_out), 0.0);
        rst_n = 1;
        @(negedge clk);
        check(busy == 0 && done == 0 && cos_out == 0 && sin_out == 0,
              "R1", "after release", real'(sin_out), 0.0);

        // R6: zero angle
        run_angle(0.0, "R6");
        check(cos_out > 65520 && cos_out < 65552, "R6", "cos(0) code",
              real'(cos_out), 65536.0);

        // R5: dense sweep across the convergence range
        for (int k = -174; k <= 174; k += 2)
            run_angle(real'(k) / 100.0, "R5");
        run_angle(1.7400, "R5");
        run_angle(-1.7400, "R5");
        run_angle(0.78539816, "R5");
        run_angle(-0.78539816, "R5");

        // R7: results hold after done
        hc = cos_out; hs = sin_out;
        repeat (7) @(negedge clk);
        check(cos_out == hc && sin_out == hs, "R7", "hold after done",
              real'(cos_out), real'(hc));

        // R4: start during busy is ignored
        angle_in = ANG_W'($rtoi(0.5 * SCALE));
        start = 1;
        @(negedge clk);
        start = 0;
        lat = 0;
        cnt_done = 0;
        repeat (4) begin @(negedge clk); lat++; end
        angle_in = ANG_W'($rtoi(-1.2 * SCALE));
        start = 1;
        @(negedge clk); lat++;
        start = 0;
        check(cos_out == hc && sin_out == hs, "R7", "hold while busy",
              real'(sin_out), real'(hs));
        while (!done && lat < 60) begin @(negedge clk); lat++; end
        check(lat == ITERS, "R4", "latency with mid-run start", real'(lat), real'(ITERS));
        c = $itor(cos_out) / SCALE;
        s = $itor(sin_out) / SCALE;
        check(absr(c - $cos(0.5)) <= TOL, "R4", "cos unaffected", c, $cos(0.5));
        check(absr(s - $sin(0.5)) <= TOL, "R4", "sin unaffected", s, $sin(0.5));
        repeat (25) begin
            @(negedge clk);
            if (done || busy) cnt_done++;
        end
        check(cnt_done == 0, "R4", "no second run", real'(cnt_done), 0.0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule